// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Access

This block is a serial peripheral master that a processor drives through two 32-bit registers on a simple write/read bus. One register holds the control settings and reports status. The other holds the byte to send and, after a transfer, the byte received. Software loads the outgoing byte first. It then writes the control word with the start bit set and polls until the busy flag drops. The received byte is then read back.

Each transfer moves exactly eight bits in both directions, most significant bit first, in clock-idle-low mode. The serial clock comes from the bus clock through a programmable divider. Three chip-select pins follow software-written control bits directly, with no automatic framing. A loopback option feeds the outgoing bit stream back into the receiver, so the data path can be tested without a slave device.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, the control register reads 0x0000_0015 and the data register reads 0. All three chip-select pins are high, and the serial clock and serial out are low.
- R2: The control register sits at byte offset 0x0 and the data register at 0x4. The data register holds bits 7:0, and a data read returns that byte with bits 31:8 zero.
- R3: An idle-time write to offset 0x0 with bit 1 set starts one 8-bit transfer. Bit 1 of the control read is 1 from the cycle after that write until the transfer ends, and 0 otherwise. Busy never rises without such a write.
- R4: The serial clock is low whenever the block is idle. Serial out carries the transmit byte MSB first: a new bit is presented at the start and on each falling clock edge, and input is sampled on each rising edge. Serial out is low when idle.
- R5: With divider value D in control bits 31:27, each serial-clock half period lasts D+1 bus cycles. Busy clears exactly 16*(D+1) cycles after the start write. The divider resets to 0.
- R6: Once busy clears, the data register holds the eight bits sampled from the serial input, first sampled bit in bit 7.
- R7: Control bit 3 set selects loopback: the received byte equals the transmitted byte, and the serial input pin has no effect.
- R8: Chip-select pin n equals control bit 2*n (n = 0, 1, 2) from the cycle after the control write.
- R9: A control write during a transfer is ignored as a whole. Chip selects, divider, loopback and the transfer's timing stay unchanged, and the transfer is not restarted.
- R10: A data-register write during a transfer does not change the bits sent. At completion the data register is overwritten with the received byte.
- R11: A control read returns the divider in bits 31:27, loopback in bit 3, busy in bit 1 and chip-select bits in 0, 2 and 4. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 3 | Chip-select pins, driven raw from control bits |

## Verification
On every cycle, the assertions check that the serial clock and serial out rest low when idle and that busy rises only after an accepted start request. They also check that the chip-select pins cannot move while a transfer is running. The bench scenarios cover what needs a complete transfer: the exact cycle busy clears for each divider, the MSB-first order seen by a modelled slave, and the received byte with and without loopback. They also cover the interference cases, where a control write or data write arrives mid-transfer and the outcome is judged at the pins and in the final register contents.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
    localparam int REG_W     = 32;
    localparam int CTRL_OFS  = 0;
    localparam int DATA_OFS  = 4;
    localparam int START_BIT = 1;
    localparam int LOOP_BIT  = 3;
    localparam int CS_COUNT  = 3;
    localparam int DIVW      = 5;
    localparam int BYTEW     = 8;

    typedef struct packed {
        logic [DIVW-1:0]     div;
        logic                loop;
        logic [CS_COUNT-1:0] cs;
        logic [BYTEW-1:0]    data;
    } regs_t;
endpackage

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
    import spi_byte_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [REG_W-1:0]    wdata,
    input  logic                busy,
    input  logic                done,
    input  logic [BYTEW-1:0]    rx_byte,
    output logic                start,
    output logic [DIVW-1:0]     div,
    output logic                loop,
    output logic [CS_COUNT-1:0] cs,
    output logic [BYTEW-1:0]    tx_byte,
    output logic [REG_W-1:0]    rdata
);
    localparam int DIV_LSB = REG_W - DIVW;

    regs_t regs_d, regs_q;
    logic  sel_ctrl, sel_data, ctrl_wr;
    logic  unused_wbits;

    assign unused_wbits = ^wdata;
    assign sel_ctrl = (addr == ADDR_W'(CTRL_OFS));
    assign sel_data = (addr == ADDR_W'(DATA_OFS));
    // control writes only land while idle
    assign ctrl_wr  = we && sel_ctrl && !busy;

    always_comb begin
        regs_d = regs_q;
        start  = ctrl_wr && wdata[START_BIT];
        if (ctrl_wr) begin
            regs_d.div  = wdata[DIV_LSB +: DIVW];
            regs_d.loop = wdata[LOOP_BIT];
            for (int n = 0; n < CS_COUNT; n++) begin
                regs_d.cs[n] = wdata[2*n];
            end
        end
        if (we && sel_data) begin
            regs_d.data = wdata[BYTEW-1:0];
        end
        // completion wins over a same-cycle bus write
        if (done) begin
            regs_d.data = rx_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.div  <= '0;
            regs_q.loop <= 1'b0;
            regs_q.cs   <= '1;
            regs_q.data <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel_ctrl) begin
            rdata[DIV_LSB +: DIVW] = regs_q.div;
            rdata[LOOP_BIT]        = regs_q.loop;
            rdata[START_BIT]       = busy;
            for (int n = 0; n < CS_COUNT; n++) begin
                rdata[2*n] = regs_q.cs[n];
            end
        end else if (sel_data) begin
            rdata[BYTEW-1:0] = regs_q.data;
        end
    end

    assign div     = regs_q.div;
    assign loop    = regs_q.loop;
    assign cs      = regs_q.cs;
    assign tx_byte = regs_q.data;
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_byte_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIVW-1:0]  div,
    input  logic             loop,
    input  logic [BYTEW-1:0] tx_byte,
    input  logic             miso,
    output logic             busy,
    output logic             done,
    output logic             sck,
    output logic             mosi,
    output logic [BYTEW-1:0] rx_byte
);
    localparam int EDGES  = 2 * BYTEW;
    localparam int CNT_W  = $clog2(EDGES);
    localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(EDGES - 1);

    typedef struct packed {
        logic             busy;
        logic             sck;
        logic [DIVW-1:0]  half;
        logic [CNT_W-1:0] edges;
        logic [BYTEW-1:0] tx;
        logic [BYTEW-1:0] rx;
    } eng_t;

    eng_t eng_d, eng_q;
    logic in_bit;

    assign in_bit = loop ? eng_q.tx[BYTEW-1] : miso;

    always_comb begin
        eng_d = eng_q;
        done  = 1'b0;
        if (!eng_q.busy) begin
            if (start) begin
                eng_d.busy  = 1'b1;
                eng_d.sck   = 1'b0;
                eng_d.half  = '0;
                eng_d.edges = '0;
                eng_d.tx    = tx_byte;
            end
        end else if (eng_q.half == div) begin
            eng_d.half  = '0;
            eng_d.sck   = !eng_q.sck;
            eng_d.edges = eng_q.edges + 1'b1;
            if (!eng_q.sck) begin
                eng_d.rx = {eng_q.rx[BYTEW-2:0], in_bit};
            end else if (eng_q.edges == LAST_EDGE) begin
                eng_d.busy = 1'b0;
                eng_d.sck  = 1'b0;
                done       = 1'b1;
            end else begin
                eng_d.tx = {eng_q.tx[BYTEW-2:0], 1'b0};
            end
        end else begin
            eng_d.half = eng_q.half + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy    = eng_q.busy;
    assign sck     = eng_q.sck;
    assign mosi    = eng_q.busy & eng_q.tx[BYTEW-1];
    assign rx_byte = eng_q.rx;
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_byte_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int NUM_CS = CS_COUNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs
);
    logic                start_req, xfer_busy, xfer_done, loop_en;
    logic [DIVW-1:0]     div_val;
    logic [CS_COUNT-1:0] cs_bits;
    logic [BYTEW-1:0]    tx_byte, rx_byte;

    spi_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_we),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .busy    (xfer_busy),
        .done    (xfer_done),
        .rx_byte (rx_byte),
        .start   (start_req),
        .div     (div_val),
        .loop    (loop_en),
        .cs      (cs_bits),
        .tx_byte (tx_byte),
        .rdata   (bus_rdata)
    );

    spi_shift_engine u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_req),
        .div     (div_val),
        .loop    (loop_en),
        .tx_byte (tx_byte),
        .miso    (spi_miso),
        .busy    (xfer_busy),
        .done    (xfer_done),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .rx_byte (rx_byte)
    );

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs_pin
        assign spi_cs[g] = cs_bits[g];
    end
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk #(
    parameter int NUM_CS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sck,
    input logic              mosi,
    input logic [NUM_CS-1:0] cs,
    input logic              busy,
    input logic              start
);
    // R4
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    // R4
    mosi_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mosi);

    // R3
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R9
    cs_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cs));

    // R5
    sck_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $past(busy));
endmodule

bind spi_byte_master spi_byte_master_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sck   (spi_sck),
    .mosi  (spi_mosi),
    .cs    (spi_cs),
    .busy  (xfer_busy),
    .start (start_req)
);

// File: tb/tb_spi_byte_master.sv
module tb_spi_byte_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        spi_sck, spi_mosi, spi_miso;
    logic [2:0]  spi_cs;

    int checks = 0;
    int fails  = 0;

    // slave model: shifts on falling edge, captures on rising edge
    logic [7:0] s_byte = 8'd0;
    logic [7:0] s_cap  = 8'd0;
    int         s_neg  = 0;
    int         s_base = 0;
    logic [2:0] s_k;

    always #2.5 clk = ~clk;

    spi_byte_master dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .spi_sck   (spi_sck),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .spi_cs    (spi_cs)
    );

    always @(negedge spi_sck) s_neg <= s_neg + 1;
    always @(posedge spi_sck) s_cap <= {s_cap[6:0], spi_mosi};
    assign s_k      = 3'(s_neg - s_base);
    assign spi_miso = s_byte[3'd7 - s_k];

    function automatic logic [31:0] mk_ctrl(input logic [4:0] d, input logic lp,
                                            input logic [2:0] cs, input logic b1);
        logic [31:0] w;
        w = 32'd0;
        w[31:27] = d;
        w[3] = lp;
        w[1] = b1;
        w[0] = cs[0];
        w[2] = cs[1];
        w[4] = cs[2];
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] w);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = w;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 4'd0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] r);
        bus_addr = a;
        #1;
        r = bus_rdata;
    endtask

    task automatic xfer(input logic [4:0] d, input logic lp, input logic [2:0] cs,
                        input logic [7:0] tx, input logic [7:0] sb, input bit intrude);
        logic [31:0] r;
        int cyc;
        logic bz;
        bus_write(4'd4, {24'd0, tx});
        s_byte = sb;
        s_base = s_neg;
        bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = mk_ctrl(d, lp, cs, 1'b1);
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
        bus_read(4'd0, r);
        check("R3 busy set after start", r, mk_ctrl(d, lp, cs, 1'b1));
        cyc = 0;
        bz  = 1'b1;
        while (bz && cyc < 2000) begin
            bus_we    = intrude && (cyc == 20 || cyc == 22);
            bus_addr  = (cyc == 22) ? 4'd4 : 4'd0;
            bus_wdata = (cyc == 22) ? 32'h0000_005A : mk_ctrl(~d, ~lp, ~cs, 1'b1);
            @(posedge clk);
            cyc++;
            @(negedge clk);
            bus_we = 1'b0;
            bus_read(4'd0, r);
            bz = r[1];
            if (intrude && cyc == 21)
                check("R9 cs pins unchanged by mid-transfer write", {29'd0, spi_cs}, {29'd0, cs});
        end
        check("R5 busy duration 16*(D+1)", cyc, 16 * (int'(d) + 1));
        check("R11 control readback after transfer", r, mk_ctrl(d, lp, cs, 1'b0));
        check("R4 MSB-first bits seen by slave", {24'd0, s_cap}, {24'd0, tx});
        bus_read(4'd4, r);
        if (lp) check("R7 loopback receives sent byte", r, {24'd0, tx});
        else if (intrude) check("R10 received byte overwrites data write", r, {24'd0, sb});
        else check("R6 received byte in data register", r, {24'd0, sb});
        check("R8 cs pins follow control bits", {29'd0, spi_cs}, {29'd0, cs});
        check("R4 idle sck/mosi low", {30'd0, spi_sck, spi_mosi}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        bus_read(4'd0, r);
        check("R1 control reset value", r, 32'h0000_0015);
        bus_read(4'd4, r);
        check("R1 data reset value", r, 32'd0);
        check("R1 cs pins high", {29'd0, spi_cs}, 32'd7);
        check("R1 sck/mosi low", {30'd0, spi_sck, spi_mosi}, 32'd0);
        // R2 data register offset and width
        bus_write(4'd4, 32'hDEAD_BEA7);
        bus_read(4'd4, r);
        check("R2 data readback zero-extended", r, 32'h0000_00A7);
        bus_read(4'd0, r);
        check("R2 control unaffected by data write", r, 32'h0000_0015);
        // R11 readback of all writable control fields, start bit clear
        bus_write(4'd0, 32'hFFFF_FFFD);
        bus_read(4'd0, r);
        check("R11 control readback masks unused bits", r, 32'hF800_001D);
        check("R3 no transfer without start bit", {31'd0, spi_sck}, 32'd0);
        bus_write(4'd0, 32'd0);
        check("R8 cs pins all low", {29'd0, spi_cs}, 32'd0);
        bus_write(4'd0, mk_ctrl(5'd0, 1'b0, 3'b010, 1'b0));
        check("R8 cs1 from bit 2", {29'd0, spi_cs}, 32'd2);
        // directed corners
        xfer(5'd0,  1'b0, 3'b110, 8'h81, 8'h3C, 1'b0);
        xfer(5'd31, 1'b0, 3'b011, 8'h5A, 8'hC3, 1'b0);
        xfer(5'd2,  1'b1, 3'b101, 8'hB4, 8'h4B, 1'b0);
        xfer(5'd3,  1'b0, 3'b100, 8'h96, 8'hE1, 1'b1);
        bus_read(4'd0, r);
        check("R9 divider/loop kept after ignored write", r, mk_ctrl(5'd3, 1'b0, 3'b100, 1'b0));
        // constrained random
        for (int i = 0; i < 14; i++) begin
            logic [4:0] d;
            logic [7:0] tx;
            d  = 5'($urandom_range(0, 3));
            tx = 8'($urandom);
            xfer(d, 1'($urandom), 3'($urandom), tx, ~tx ^ 8'($urandom), 1'b0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule